// File: doc/BRIEF.md
# SPI Master with Selectable Input Sample Point

This block is a single-frame SPI master transfer engine. A start strobe loads an 8-bit frame. The block shifts that frame out on the serial data output, most significant bit first, in clock mode 0: the serial clock idles low and data changes on its falling edge. It captures the serial data input at the same time. One chip-select line brackets the frame. Its inactive level is set by a polarity input, and its active level is the opposite.

For slave paths with a long round-trip delay, a delayed capture format can be enabled. In that format the input is not captured on the rising clock edge. It is captured at the falling (driving) edge itself, or one or two system clocks after it, as chosen by a 2-bit sample-point code. A one-cycle done pulse marks the capture of the last bit, and the received frame appears on the data output in that same cycle.

The controller is a five-state machine:
- `S_IDLE`: waits for start. `S_IDLE -> S_LEAD` on a start strobe.
- `S_LEAD`: chip select is active and the clock is low for one half-period. `S_LEAD -> S_HIGH` at the end of the half-period.
- `S_HIGH`: the clock is high. At the end of the half-period it moves `S_HIGH -> S_LOW` for the first seven bits and `S_HIGH -> S_TRAIL` after the eighth.
- `S_LOW`: the clock is low between bits. `S_LOW -> S_HIGH` at the end of the half-period.
- `S_TRAIL`: holds chip select for one half-period after the final falling edge. `S_TRAIL -> S_IDLE` at the end of the half-period.

Top module: `spi_sample_master`

## Requirements
- R1: After reset, sclk_o and mosi_o are low, done_o is low, and cs_o equals cs_idle_i.
- R2: The frame latched at start leaves on mosi_o most significant bit first. Each bit is stable at the rising sclk_o edge and changes on the falling edge.
- R3: Let cycle 0 be the clock edge at which start is accepted. Every sclk_o level lasts HALF_CYC cycles. The first rising edge comes at cycle HALF_CYC. cs_o stays active through cycle 17*HALF_CYC-1 and returns to idle at cycle 17*HALF_CYC.
- R4: With mod_fmt_i=0, miso_i is captured on each rising sclk_o edge, and done_o rises 15*HALF_CYC cycles after cycle 0.
- R5: With mod_fmt_i=1, miso_i is captured at the falling-edge cycle for code 2'b00, one cycle later for 2'b01, and two cycles later for 2'b10. done_o rises 16*HALF_CYC+d cycles after cycle 0, where d is that delay.
- R6: Code 2'b11 behaves exactly like code 2'b00.
- R7: cs_idle_i=0 gives an idle-low, active-high chip select; cs_idle_i=1 gives the inverse.
- R8: done_o is high for exactly one cycle per frame. rx_data_o carries the received frame (first received bit in bit 7) from that cycle until the next frame completes.
- R9: A start strobe during a frame is ignored. The frame data, format, sample code and polarity are taken only at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted while idle |
| tx_data_i | input | FRAME_BITS | Frame to transmit |
| mod_fmt_i | input | 1 | 1 selects delayed-capture format |
| smpl_sel_i | input | 2 | Sample-point code for delayed-capture format |
| cs_idle_i | input | 1 | Inactive level of the chip select |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the slave |
| cs_o | output | 1 | Chip select |
| rx_data_o | output | FRAME_BITS | Received frame |
| done_o | output | 1 | One-cycle frame-complete pulse |

## Verification
The bench builds the block with HALF_CYC=3, the smallest allowed half-period. At that value the two-cycle sample point lands in the last cycle before the next rising edge, and the last delayed capture falls one cycle before chip select is released. A slave model responds to each falling edge after 0, 1 or 2 system clocks. Pairing each sample code with each response latency shows the exact boundary: a capture at or before the slave's update gets the right bit, and a later one gets the next bit. This makes the code-to-delay mapping observable at the ports.

// File: rtl/spi_smp_pkg.sv
package spi_smp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_HIGH,
        S_LOW,
        S_TRAIL
    } xfer_state_t;

    // Reserved code 2'b11 folds onto the zero-delay point.
    function automatic logic [1:0] eff_delay(input logic [1:0] code);
        return (code == 2'b11) ? 2'b00 : code;
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int unsigned HALF_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: half-period ends are never back to back
    a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             shift_i,
    output logic             msb_o
);
    logic [WIDTH-1:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else if (load_i) begin
            q <= data_i;
        end else if (shift_i) begin
            q <= {q[WIDTH-2:0], 1'b0};
        end
    end

    assign msb_o = q[WIDTH-1];

endmodule

// File: rtl/spi_rx_sampler.sv
module spi_rx_sampler #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             mod_i,
    input  logic [1:0]       dly_i,
    input  logic             sdi_i,
    output logic [WIDTH-1:0] rx_data_o,
    output logic             done_o
);
    localparam int unsigned IDX_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WIDTH - 1);

    logic [1:0]       fall_dq;
    logic             take;
    logic [IDX_W-1:0] idx_q;
    logic [WIDTH-2:0] sh_q;

    // delayed copies of the driving-edge pulse
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fall_dq <= '0;
        end else begin
            fall_dq <= {fall_dq[0], fall_i};
        end
    end

    always_comb begin
        if (!mod_i) begin
            take = rise_i;
        end else begin
            unique case (dly_i)
                2'b01:   take = fall_dq[0];
                2'b10:   take = fall_dq[1];
                default: take = fall_i;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            idx_q     <= '0;
            sh_q      <= '0;
            rx_data_o <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (clr_i) begin
                idx_q <= '0;
            end else if (take) begin
                if (idx_q == LAST) begin
                    rx_data_o <= {sh_q, sdi_i};
                    done_o    <= 1'b1;
                    idx_q     <= '0;
                end else begin
                    sh_q  <= {sh_q[WIDTH-3:0], sdi_i};
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // R5: successive captures are at least two cycles apart
    a_r5_capture_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |=> !take);

    // R8: the frame output only moves together with the done pulse
    a_r8_rx_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(rx_data_o));

endmodule

// File: rtl/spi_sample_master.sv
module spi_sample_master
    import spi_smp_pkg::*;
#(
    parameter int unsigned HALF_CYC   = 4,
    parameter int unsigned FRAME_BITS = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic [FRAME_BITS-1:0] tx_data_i,
    input  logic                  mod_fmt_i,
    input  logic [1:0]            smpl_sel_i,
    input  logic                  cs_idle_i,
    input  logic                  miso_i,
    output logic                  sclk_o,
    output logic                  mosi_o,
    output logic                  cs_o,
    output logic [FRAME_BITS-1:0] rx_data_o,
    output logic                  done_o
);
    localparam int unsigned BIT_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    xfer_state_t      state_q, state_d;
    logic             tick, run, accept, rise_p, fall_p, tx_msb;
    logic [BIT_W-1:0] fall_cnt_q;
    logic             pol_q, mod_q;
    logic [1:0]       dly_q;

    assign run    = (state_q != S_IDLE);
    assign accept = (state_q == S_IDLE) && start_i;
    assign rise_p = tick && ((state_q == S_LEAD) || (state_q == S_LOW));
    assign fall_p = tick && (state_q == S_HIGH);

    spi_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .tick_o (tick)
    );

    spi_tx_shift #(.WIDTH(FRAME_BITS)) u_tx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (accept),
        .data_i  (tx_data_i),
        .shift_i (fall_p),
        .msb_o   (tx_msb)
    );

    spi_rx_sampler #(.WIDTH(FRAME_BITS)) u_rx (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (accept),
        .rise_i    (rise_p),
        .fall_i    (fall_p),
        .mod_i     (mod_q),
        .dly_i     (dly_q),
        .sdi_i     (miso_i),
        .rx_data_o (rx_data_o),
        .done_o    (done_o)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_LEAD;
            S_LEAD:  if (tick)    state_d = S_HIGH;
            S_HIGH:  if (tick)    state_d = (fall_cnt_q == LAST_BIT) ? S_TRAIL : S_LOW;
            S_LOW:   if (tick)    state_d = S_HIGH;
            S_TRAIL: if (tick)    state_d = S_IDLE;
            default:              state_d = S_IDLE;
        endcase
    end

    // bit count and per-frame settings
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fall_cnt_q <= '0;
            pol_q      <= 1'b0;
            mod_q      <= 1'b0;
            dly_q      <= 2'b00;
        end else if (accept) begin
            fall_cnt_q <= '0;
            pol_q      <= cs_idle_i;
            mod_q      <= mod_fmt_i;
            dly_q      <= eff_delay(smpl_sel_i);
        end else if (fall_p) begin
            fall_cnt_q <= fall_cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        sclk_o = (state_q == S_HIGH);
        mosi_o = run ? tx_msb : 1'b0;
        cs_o   = (state_q == S_IDLE) ? cs_idle_i : ~pol_q;
    end

    // R3: the serial clock only moves at a half-period boundary
    a_r3_sclk_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sclk_o != $past(sclk_o)) |-> $past(tick));

    // R8: one done cycle per frame
    a_r8_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R4 R5: completion only while the clock is high or in the trailing phase
    a_r5_done_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ((state_q == S_HIGH) || (state_q == S_TRAIL)));

    // R9: per-frame settings do not move once a frame runs
    a_r9_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run |=> ($stable(pol_q) && $stable(mod_q) && $stable(dly_q)));

endmodule

// File: tb/tb_spi_sample_master.sv
`timescale 1ns/1ps
module tb_spi_sample_master;
    localparam int H = 3;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] tx_data_i = '0;
    logic       mod_fmt_i = 1'b0;
    logic [1:0] smpl_sel_i = '0;
    logic       cs_idle_i = 1'b0;
    logic       miso_i = 1'b0;
    logic       sclk_o, mosi_o, cs_o, done_o;
    logic [7:0] rx_data_o;

    int errors = 0;
    int checks = 0;

    spi_sample_master #(.HALF_CYC(H), .FRAME_BITS(8)) dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tx_data_i(tx_data_i),
        .mod_fmt_i(mod_fmt_i), .smpl_sel_i(smpl_sel_i), .cs_idle_i(cs_idle_i),
        .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_o(cs_o),
        .rx_data_o(rx_data_o), .done_o(done_o)
    );

    always #5 clk_i = ~clk_i;

    // slave model state
    logic [7:0] sbyte = '0;
    logic [7:0] mosi_cap = '0;
    logic       pol_cur = 1'b0;
    int         slat = 0;
    int         sidx = 0;
    int         cd = 0;
    logic       sck_prev = 1'b0;
    logic       cs_prev = 1'b0;
    logic       cs_act;

    task automatic slave_step();
        sidx = sidx - 1;
        miso_i = (sidx >= 0) ? sbyte[sidx] : 1'b0;
    endtask

    always @(negedge clk_i) begin
        cs_act = rst_ni && (cs_o != pol_cur);
        if (cs_act && !cs_prev) begin
            sidx = 7;
            miso_i = sbyte[7];
            cd = 0;
        end
        if (cd > 0) begin
            cd = cd - 1;
            if (cd == 0) slave_step();
        end
        if (cs_act && sck_prev && !sclk_o) begin
            if (slat == 0) slave_step();
            else cd = slat;
        end
        if (cs_act && !sck_prev && sclk_o) mosi_cap = {mosi_cap[6:0], mosi_o};
        sck_prev = sclk_o;
        cs_prev = cs_act;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rx(input logic [7:0] sb, input bit m, input logic [1:0] code, input int lat);
        int d;
        d = (code == 2'b11) ? 0 : int'(code);
        if (!m || d <= lat) return sb;
        return {sb[6:0], 1'b0};
    endfunction

    function automatic int exp_lat(input bit m, input logic [1:0] code);
        int d;
        d = (code == 2'b11) ? 0 : int'(code);
        return m ? (16 * H + d) : (15 * H);
    endfunction

    task automatic run_frame(input logic [7:0] tx, input logic [7:0] sb, input bit m,
                             input logic [1:0] code, input bit p, input int lat, input bit inject);
        int got, ndone, cyc;
        logic cs_a, cs_b, sck_a, sck_b;
        logic [7:0] erx;
        string rq;
        @(negedge clk_i);
        tx_data_i = tx; mod_fmt_i = m; smpl_sel_i = code; cs_idle_i = p;
        pol_cur = p; sbyte = sb; slat = lat; mosi_cap = '0;
        repeat (2) @(negedge clk_i);
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        chk(cs_o == ~p, "R7", "cs active level", cs_o, ~p);
        got = -1; ndone = 0;
        cs_a = 1'b0; cs_b = 1'b0; sck_a = 1'b1; sck_b = 1'b0;
        for (cyc = 1; cyc <= 17 * H + 1; cyc++) begin
            @(negedge clk_i);
            if (done_o) begin
                ndone++;
                if (got < 0) got = cyc;
            end
            if (cyc == H - 1) sck_a = sclk_o;
            if (cyc == H) sck_b = sclk_o;
            if (cyc == 17 * H - 1) cs_a = cs_o;
            if (cyc == 17 * H) cs_b = cs_o;
            if (inject && cyc == 10) begin
                start_i = 1'b1; tx_data_i = ~tx; mod_fmt_i = ~m; smpl_sel_i = code + 2'b01;
            end
            if (inject && cyc == 11) start_i = 1'b0;
        end
        erx = exp_rx(sb, m, code, lat);
        rq = inject ? "R9" : (m ? ((code == 2'b11) ? "R6" : "R5") : "R4");
        chk(got == exp_lat(m, code), rq, "done latency", got, exp_lat(m, code));
        chk(rx_data_o == erx, rq, "received frame", rx_data_o, erx);
        chk(mosi_cap == tx, inject ? "R9" : "R2", "transmitted bits", mosi_cap, tx);
        chk(ndone == 1, "R8", "done pulse count", ndone, 1);
        chk(sck_a == 1'b0 && sck_b == 1'b1, "R3", "first rising edge", {sck_a, sck_b}, 2'b01);
        chk(cs_a == ~p, "R3", "cs held to last cycle", cs_a, ~p);
        chk(cs_b == p, "R3", "cs released", cs_b, p);
        repeat (3) @(negedge clk_i);
        chk(rx_data_o == erx, "R8", "frame held", rx_data_o, erx);
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        cs_idle_i = 1'b1;
        #2;
        chk(cs_o == 1'b1, "R1", "cs in reset, idle high", cs_o, 1);
        cs_idle_i = 1'b0;
        #2;
        chk(cs_o == 1'b0, "R1", "cs in reset, idle low", cs_o, 0);
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        chk(sclk_o == 1'b0, "R1", "sclk idle", sclk_o, 0);
        chk(mosi_o == 1'b0, "R1", "mosi idle", mosi_o, 0);
        chk(done_o == 1'b0, "R1", "done idle", done_o, 0);

        // directed corners
        run_frame(8'hA5, 8'h3C, 1'b0, 2'b00, 1'b0, 0, 1'b0);
        run_frame(8'h81, 8'hC3, 1'b0, 2'b10, 1'b1, 2, 1'b0);
        run_frame(8'h5A, 8'hF0, 1'b1, 2'b00, 1'b0, 0, 1'b0);
        run_frame(8'h0F, 8'h96, 1'b1, 2'b01, 1'b0, 0, 1'b0);
        run_frame(8'hFF, 8'h96, 1'b1, 2'b01, 1'b1, 1, 1'b0);
        run_frame(8'h00, 8'hB7, 1'b1, 2'b10, 1'b0, 1, 1'b0);
        run_frame(8'h7E, 8'hB7, 1'b1, 2'b10, 1'b1, 2, 1'b0);
        run_frame(8'hC6, 8'h69, 1'b1, 2'b11, 1'b0, 0, 1'b0);
        run_frame(8'h39, 8'hE1, 1'b1, 2'b00, 1'b1, 1, 1'b1);

        // random mix
        for (int i = 0; i < 40; i++) begin
            run_frame(8'($urandom), 8'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                      int'($urandom % 3), ($urandom % 4) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule